// File: doc/BRIEF.md
# Serial Flash Command Shift Engine

This block runs one serial-flash transaction at a time on behalf of a host processor. The host first writes the command word, which packs an 8-bit opcode with a 24-bit flash address. It may also write up to four payload bytes into a data register. It then writes a control word that carries a transmit byte count, a receive byte count and a start bit.

The engine lowers chip select and clocks out the requested bytes in SPI mode 0. In the same frame it reads the requested number of reply bytes from the serial input. Those bytes are packed, first byte lowest, into the data register, where the host reads them once the busy flag drops.

A single frame covers every common flash operation:
- enable writes: one byte out;
- read status: one out, one in;
- read data: four out, four in;
- read the device signature: four out, one in;
- program: eight out, that is opcode, three address bytes and four payload bytes.

Top module: `spi_cmd_engine`

## Requirements
- R1: Registers sit at byte offsets 0x0 (control), 0x4 (command word) and 0x8 (data). Control reads back bits 3:0 as the transmit count, bits 7:4 as the receive count, bit 16 as busy, and bit 8 (start) as zero. After reset every register reads zero, chip select is high and the serial clock is low.
- R2: Writing control with bit 8 set while idle, and with a non-zero transmit count, starts a frame. Busy reads 1 from the next cycle until the frame has ended.
- R3: The bytes sent are, in order: the opcode (command bits 7:0), then command bits 31:24, 23:16 and 15:8, then data bits 7:0, 15:8, 23:16 and 31:24. The transmit count selects how many of these are sent, starting from the first. Every byte goes out most significant bit first.
- R4: A frame has exactly 8 x (transmit + receive) serial clock pulses. The serial output is held low during the receive bytes.
- R5: The serial input is sampled on rising serial clock edges, most significant bit first. Received byte k lands in data bits 8k+7:8k. Data bytes beyond the receive count are unspecified.
- R6: The serial clock idles low. The serial output changes only while the serial clock is low (mode 0).
- R7: Chip select stays low for the whole frame and rises one serial clock period after the final falling clock edge. Busy stays set for as long as chip select is low and drops only after chip select has risen.
- R8: While busy, every register write, including a new start request, is ignored.
- R9: A start request with a transmit count of zero leaves chip select high and busy low.
- R10: The serial clock period equals CLK_DIV system clocks, with CLK_DIV an even number of at least 2, and a 50% duty cycle.
- R11: A transmit count above 8 acts as 8, and a receive count above 4 acts as 4. The control register still reads back the values as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Two events can fall in the same system cycle: a host write and an active shift step. The sharpest case is a start request that lands while a frame is running. The bench provokes this by writing a new control word with start set, and a new command word, in the middle of a two-byte frame. It then judges the outcome at the pins and through the registers. The clock-pulse count must still match the first frame, and the command and control registers must read back their earlier values.

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine #(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW = $clog2(CLK_DIV) + 1;
  localparam logic [DW-1:0] HALF_M1 = DW'(HALF - 1);
  localparam logic [DW-1:0] FULL_M1 = DW'(CLK_DIV - 1);
  localparam logic [3:0] OFS_CTL = 4'h0;
  localparam logic [3:0] OFS_CMD = 4'h4;
  localparam logic [3:0] OFS_DAT = 4'h8;
  localparam logic [3:0] MAX_TX = 4'd8;
  localparam logic [3:0] MAX_RX = 4'd4;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_TAIL, S_GAP} state_t;

  state_t          st_q;
  logic [31:0]     cmd_q, data_q;
  logic [3:0]      txc_q, rxc_q;
  logic            busy_q, cs_n_q, sck_q;
  logic [DW-1:0]   div_q;
  logic [63:0]     sr_q;
  logic [7:0]      rx_sh_q;
  logic [2:0]      bit_q;
  logic [3:0]      byte_q;
  logic [1:0]      rxi_q;

  logic [3:0] tx_n, rx_n, nbytes, wr_tx;
  logic       in_tx, wr_ok, start_req;

  assign tx_n   = (txc_q > MAX_TX) ? MAX_TX : txc_q;
  assign rx_n   = (rxc_q > MAX_RX) ? MAX_RX : rxc_q;
  assign nbytes = tx_n + rx_n;
  assign in_tx  = byte_q < tx_n;
  assign wr_tx  = (bus_wdata[3:0] > MAX_TX) ? MAX_TX : bus_wdata[3:0];

  assign wr_ok     = bus_we && !busy_q;
  assign start_req = wr_ok && (bus_addr == OFS_CTL) && bus_wdata[8];

  assign spi_cs_n = cs_n_q;
  assign spi_sck  = sck_q;
  assign spi_mosi = (st_q == S_SHIFT) && in_tx && sr_q[63];

  always_comb begin
    case (bus_addr)
      OFS_CTL: bus_rdata = {15'd0, busy_q, 8'd0, rxc_q, txc_q};
      OFS_CMD: bus_rdata = cmd_q;
      OFS_DAT: bus_rdata = data_q;
      default: bus_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cmd_q   <= '0;
      data_q  <= '0;
      txc_q   <= '0;
      rxc_q   <= '0;
      busy_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      sck_q   <= 1'b0;
      div_q   <= '0;
      sr_q    <= '0;
      rx_sh_q <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      rxi_q   <= '0;
    end else begin
      if (wr_ok && bus_addr == OFS_CMD) cmd_q <= bus_wdata;
      if (wr_ok && bus_addr == OFS_DAT) data_q <= bus_wdata;
      if (wr_ok && bus_addr == OFS_CTL) begin
        txc_q <= bus_wdata[3:0];
        rxc_q <= bus_wdata[7:4];
      end
      case (st_q)
        S_IDLE: begin
          if (start_req && wr_tx != 4'd0) begin
            st_q   <= S_SHIFT;
            busy_q <= 1'b1;
            cs_n_q <= 1'b0;
            sck_q  <= 1'b0;
            div_q  <= '0;
            bit_q  <= '0;
            byte_q <= '0;
            rxi_q  <= '0;
            sr_q   <= {cmd_q[7:0], cmd_q[31:8], data_q[7:0], data_q[15:8],
                       data_q[23:16], data_q[31:24]};
          end
        end
        S_SHIFT: begin
          if (div_q == HALF_M1) begin
            div_q <= '0;
            sck_q <= ~sck_q;
            if (!sck_q) begin
              if (!in_tx) rx_sh_q <= {rx_sh_q[6:0], spi_miso};
            end else begin
              sr_q  <= {sr_q[62:0], 1'b0};
              bit_q <= bit_q + 3'd1;
              if (bit_q == 3'd7) begin
                byte_q <= byte_q + 4'd1;
                if (!in_tx) begin
                  data_q[{rxi_q, 3'b000} +: 8] <= rx_sh_q;
                  rxi_q <= rxi_q + 2'd1;
                end
                if (byte_q == nbytes - 4'd1) st_q <= S_TAIL;
              end
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        S_TAIL: begin
          if (div_q == FULL_M1) begin
            div_q  <= '0;
            cs_n_q <= 1'b1;
            st_q   <= S_GAP;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        default: begin
          busy_q <= 1'b0;
          st_q   <= S_IDLE;
        end
      endcase
    end
  end

  p_cs_needs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_q |-> busy_q);
  p_busy_ends_after_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(cs_n_q));
  p_sck_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sck_q);
  p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bus_we) |=> ($stable(txc_q) && $stable(rxc_q) && $stable(cmd_q)));
  p_zero_tx_stays_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && bus_wdata[3:0] == 4'd0) |=> (!busy_q && cs_n_q));
  p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && bus_wdata[3:0] != 4'd0) |=> (busy_q && !cs_n_q));
endmodule

// File: tb/sim_spi_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_cmd_engine;
  localparam int CDIV = 4;
  localparam int TCLK = 20;
  localparam int NV = 7;
  // {tx[3:0], rx[3:0], cmd[31:0], data[31:0], resp[31:0]}
  localparam logic [103:0] VEC [0:NV-1] = '{
    {4'd1, 4'd0, 32'h0000_0006, 32'h0000_0000, 32'h0000_0000},
    {4'd1, 4'd1, 32'h0000_0005, 32'h0000_0000, 32'h0000_0003},
    {4'd4, 4'd4, 32'h1234_5603, 32'h0000_0000, 32'hA1B2_C3D4},
    {4'd4, 4'd1, 32'h0000_00AB, 32'h0000_0000, 32'h0000_0017},
    {4'd8, 4'd0, 32'h00AB_CD02, 32'hDEAD_BEEF, 32'h0000_0000},
    {4'd5, 4'd2, 32'h0102_030B, 32'h0000_0055, 32'h0000_9A6C},
    {4'hF, 4'hF, 32'hC3A5_5A3C, 32'h8421_1248, 32'h5AA5_0FF0}
  };

  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic spi_cs_n, spi_sck, spi_mosi, spi_miso;

  always #(TCLK/2) clk = ~clk;

  spi_cmd_engine #(.CLK_DIV(CDIV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int total = 0, bad = 0;
  bit finished = 0;
  int cur_tx = 0, cur_rx = 0;
  logic [31:0] cur_resp = 0;
  int rise_n = 0, per_bad = 0, mode_bad = 0, cs_bad = 0;
  logic [95:0] cap = 0;
  longint last_rise = 0, last_fall = 0, tail_t = 0;

  always @(posedge spi_sck or negedge spi_cs_n) begin
    if (spi_sck) begin
      if (rise_n > 0 && ($time - last_rise) != CDIV*TCLK) per_bad++;
      last_rise = $time;
      if (rise_n < 96) cap[rise_n] = spi_mosi;
      rise_n++;
    end else begin
      rise_n = 0;
      cap = 0;
    end
  end
  always @(negedge spi_sck) last_fall = $time;
  always @(posedge spi_cs_n) tail_t = $time - last_fall;

  always_comb begin
    int p;
    p = rise_n - 8*cur_tx;
    if (!spi_cs_n && p >= 0 && p < 8*cur_rx)
      spi_miso = cur_resp[8*(p/8) + 7 - (p%8)];
    else
      spi_miso = 1'b0;
  end

  logic prev_sck = 0, prev_mosi = 0;
  always @(negedge clk) begin
    if (!spi_cs_n && prev_sck && spi_sck && spi_mosi != prev_mosi) mode_bad++;
    if (!spi_cs_n && !bus_rdata[16] && bus_addr == 4'h0) cs_bad++;
    if (spi_cs_n && spi_sck) mode_bad++;
    prev_sck = spi_sck;
    prev_mosi = spi_mosi;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0; bus_addr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    int n = 0;
    do begin rd(4'h0, c); n++; end while (c[16] && n < 5000);
  endtask

  function automatic logic [7:0] tx_byte(int j, logic [31:0] c, logic [31:0] d);
    case (j)
      0: return c[7:0];
      1: return c[31:24];
      2: return c[23:16];
      3: return c[15:8];
      default: return d[8*(j-4) +: 8];
    endcase
  endfunction

  initial begin
    #(200000*TCLK);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'h0, r); check(r == 0, "R1", "ctl reset", r, 0);
    rd(4'h4, r); check(r == 0, "R1", "cmd reset", r, 0);
    rd(4'h8, r); check(r == 0, "R1", "data reset", r, 0);
    check(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1", "pins reset",
          {spi_cs_n, spi_sck}, 2'b10);

    for (int v = 0; v < NV; v++) begin
      logic [3:0] tw, rw;
      logic [31:0] cm, da, rs, expd, mask;
      logic [95:0] expm, mk;
      int tn, rn;
      {tw, rw, cm, da, rs} = VEC[v];
      tn = (tw > 8) ? 8 : int'(tw);
      rn = (rw > 4) ? 4 : int'(rw);
      cur_tx = tn; cur_rx = rn; cur_resp = rs;
      wr(4'h4, cm);
      wr(4'h8, da);
      wr(4'h0, {23'd0, 1'b1, rw, tw});
      rd(4'h0, r);
      check(r[16] == 1'b1, "R2", "busy after start", r[16], 1);
      wait_idle();
      check(rise_n == 8*(tn+rn), "R4", "clock pulses", rise_n, 8*(tn+rn));
      expm = 0; mk = 0;
      for (int i = 0; i < 8*(tn+rn); i++) begin
        mk[i] = 1'b1;
        expm[i] = (i < 8*tn) ? tx_byte(i/8, cm, da)[7-(i%8)] : 1'b0;
      end
      check((cap & mk) == expm, (tn > 4) ? "R3/R11" : "R3", "mosi bits",
            cap & mk, expm);
      mask = 0; expd = 0;
      for (int k = 0; k < rn; k++) begin
        mask[8*k +: 8] = 8'hFF;
        expd[8*k +: 8] = rs[8*k +: 8];
      end
      rd(4'h8, r);
      check((r & mask) == expd, "R5", "received data", r & mask, expd);
      check(tail_t == CDIV*TCLK, "R7", "cs tail", tail_t, CDIV*TCLK);
      rd(4'h0, r);
      check(r == {24'd0, rw, tw}, "R11", "ctl readback", r, {24'd0, rw, tw});
    end
    check(per_bad == 0, "R10", "sck period", per_bad, 0);
    check(mode_bad == 0, "R6", "mode 0 edges", mode_bad, 0);
    check(cs_bad == 0, "R7", "cs low without busy", cs_bad, 0);

    // R9 zero transmit count
    begin
      int seen = 0;
      wr(4'h0, 32'h0000_0120);
      repeat (20) begin
        @(negedge clk);
        if (!spi_cs_n || bus_rdata[16]) seen++;
      end
      check(seen == 0, "R9", "zero tx activity", seen, 0);
      rd(4'h0, r); check(r == 32'h20, "R9", "ctl after zero start", r, 32'h20);
    end

    // R8 writes during a frame
    cur_tx = 2; cur_rx = 0; cur_resp = 0;
    wr(4'h4, 32'h0011_2299);
    wr(4'h0, 32'h0000_0102);
    repeat (10) @(negedge clk);
    wr(4'h0, 32'h0000_0148);
    wr(4'h4, 32'hFFFF_FFFF);
    wait_idle();
    repeat (5) @(negedge clk);
    check(rise_n == 16, "R8", "pulses with late start", rise_n, 16);
    rd(4'h4, r); check(r == 32'h0011_2299, "R8", "cmd kept", r, 32'h0011_2299);
    rd(4'h0, r); check(r == 32'h2, "R8", "ctl kept", r, 32'h2);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule